// File: doc/BRIEF.md
# Banked RAM March Self-Test Engine

This block is a hardware sequencer that tests a bank-switched RAM window through the same byte-wide bus a processor would use. After a start request it selects each bank in turn by writing the bank number to an I/O port. It then visits every location of the 16K window at C000H. At each location it writes zeros and reads them back, then writes ones and reads them back, and finally leaves the bank number behind as a tag.

A second pass selects every bank again and reads the whole window, expecting each byte to equal the number of its own bank. A bank whose decode overlaps another bank loses its tags to the later bank, so this pass finds aliasing between banks that the pattern pass cannot see. The engine stops at the first mismatch and holds the location, bank, expected byte and observed byte for software or a tester to read. Every bus access lasts a fixed, parameterised number of clocks, so slow memory can sit behind the port.

Top module: `ram_march_bist`

## Requirements
- R1: A one-cycle `start` while idle begins a run and raises `busy` on the next cycle; `start` while `busy` is high has no effect on the sequence or its length.
- R2: Before testing a bank the engine asserts `io_wr` with `io_addr` = 70H and `mem_wdata` = bank number; banks 1 to 15 are selected in ascending order in each of the two passes, 30 selects in a clean run.
- R3: Every memory read or write addresses C000H plus an offset inside the window (2^WIN_AW bytes), offsets taken in ascending order within each bank.
- R4: At each location of the first pass the engine writes 00H, reads and compares, writes FFH, reads and compares, then writes the bank number; in a clean run every location of banks 1 to 15 ends up holding its bank number and bank 0 is untouched.
- R5: The second pass reads every location of banks 1 to 15 and compares it with the bank number, so a bank that aliases an earlier one is reported at the earlier bank's first location.
- R6: At the first mismatch the engine stops, raises `fail`, and latches `fail_addr`, `fail_bank`, `fail_exp` and `fail_obs`; these hold until the next start, which clears `fail`.
- R7: `done` is a one-cycle pulse when a run ends with `busy` low; with `fail` low it appears only after the second pass has finished all 15 banks.
- R8: Each access holds its strobe for exactly ACC_CYC cycles; a clean run keeps `busy` high for 15 x ACC_CYC x (2 + 6 x 2^WIN_AW) cycles.
- R9: A synchronous active-low `rst_n` returns the engine to idle with `busy`, `done`, `fail` and all bus strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a test run when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| fail | output | 1 | Last run stopped on a mismatch |
| fail_addr | output | 16 | Bus address of the first mismatch |
| fail_bank | output | 8 | Bank selected at the first mismatch |
| fail_exp | output | 8 | Byte expected at the first mismatch |
| fail_obs | output | 8 | Byte read at the first mismatch |
| io_wr | output | 1 | Bank port write strobe |
| io_addr | output | 8 | I/O port address |
| mem_wr | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data for memory and bank port |
| mem_rdata | input | 8 | Read data from memory |

## Verification
The bench puts faults into its memory model and checks where the engine stops. A bit stuck at one in the very first location must stop the zero read with 00H expected; an engine that compared late or started at the wrong offset would name a different address. A bit stuck at zero in the last location of bank 15 must stop the ones read; an engine with an end-of-window or end-of-bank error would finish clean or stop elsewhere. A model that ignores the top bank-select bit must pass the first pass and fail at bank 1, location C000H, with tag 09H observed; a design without the tag pass would report success. Starting during a run, resetting mid-run, and a clean run after a failed one check that the run length stays fixed and that stale failure data is cleared.

// File: rtl/tst_pkg.sv
// Shared types for the banked RAM march self-test engine.
// Assumes one bus operation is in flight at a time.
package tst_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SEL  = 3'd1,
        ST_WR0  = 3'd2,
        ST_RD0  = 3'd3,
        ST_WR1  = 3'd4,
        ST_RD1  = 3'd5,
        ST_WTAG = 3'd6,
        ST_RTAG = 3'd7
    } tst_state_t;

    localparam logic [7:0] PAT_ZERO = 8'h00;
    localparam logic [7:0] PAT_ONES = 8'hFF;
endpackage

// File: rtl/tst_cycle_timer.sv
// Access timer: counts the cycles of the current bus operation and flags
// its final cycle. Assumes run stays high for back-to-back operations.
module tst_cycle_timer #(
    parameter int ACC_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int CW = (ACC_CYC > 1) ? $clog2(ACC_CYC) : 1;
    localparam logic [CW-1:0] LAST_V = CW'(ACC_CYC - 1);

    logic [CW-1:0] cnt;

    // Cycle counter: advances while running, wraps after the final cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = run && (cnt == LAST_V);

    generate
        if (ACC_CYC > 1) begin : g_chk
            // R8: a final cycle is never followed at once by another final cycle
            a_r8_no_short_access: assert property (@(posedge clk) disable iff (!rst_n)
                last |=> !last);
        end
    endgenerate
endmodule

// File: rtl/tst_walk_counter.sv
// Location walker: holds the window offset and the selected bank, steps the
// offset in ascending order and moves to the next bank at the window end.
// Assumes step and restart are never high together.
module tst_walk_counter #(
    parameter int WIN_AW     = 14,
    parameter int FIRST_BANK = 1,
    parameter int LAST_BANK  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    output logic [WIN_AW-1:0] offs,
    output logic [7:0]        bank,
    output logic              offs_end,
    output logic              bank_end
);
    localparam logic [7:0] FIRST_V = 8'(FIRST_BANK);
    localparam logic [7:0] LAST_V  = 8'(LAST_BANK);

    // Offset and bank registers.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            offs <= '0;
            bank <= FIRST_V;
        end else if (step) begin
            if (offs_end) begin
                offs <= '0;
                bank <= bank + 8'd1;
            end else begin
                offs <= offs + 1'b1;
            end
        end
    end

    assign offs_end = &offs;
    assign bank_end = (bank == LAST_V);

    // R2: the selected bank never leaves the tested range
    a_r2_bank_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (bank >= FIRST_V && bank <= LAST_V));
endmodule

// File: rtl/ram_march_bist.sv
// Banked RAM march self-test engine. Selects each bank through the bank
// port, runs zero/ones/tag writes and reads on every window location, then
// re-reads every bank's tags. Stops at the first mismatch.
// Assumes memory read data is valid in the final cycle of a read access.
module ram_march_bist #(
    parameter int          WIN_AW     = 14,
    parameter logic [15:0] WIN_BASE   = 16'hC000,
    parameter int          FIRST_BANK = 1,
    parameter int          LAST_BANK  = 15,
    parameter logic [7:0]  BANK_PORT  = 8'h70,
    parameter int          ACC_CYC    = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        busy,
    output logic        done,
    output logic        fail,
    output logic [15:0] fail_addr,
    output logic [7:0]  fail_bank,
    output logic [7:0]  fail_exp,
    output logic [7:0]  fail_obs,
    output logic        io_wr,
    output logic [7:0]  io_addr,
    output logic        mem_wr,
    output logic        mem_rd,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata
);
    import tst_pkg::*;

    tst_state_t        state;
    logic              pass2;
    logic              last;
    logic [WIN_AW-1:0] offs;
    logic [7:0]        bank;
    logic              offs_end, bank_end;
    logic              is_read, loc_done, mismatch, all_done;
    logic              walk_restart, walk_step;
    logic [7:0]        exp_byte;

    tst_cycle_timer #(.ACC_CYC(ACC_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .last  (last)
    );

    tst_walk_counter #(
        .WIN_AW     (WIN_AW),
        .FIRST_BANK (FIRST_BANK),
        .LAST_BANK  (LAST_BANK)
    ) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (walk_restart),
        .step     (walk_step),
        .offs     (offs),
        .bank     (bank),
        .offs_end (offs_end),
        .bank_end (bank_end)
    );

    // Bus strobe, address and data decode from the current operation.
    always_comb begin
        busy      = (state != ST_IDLE);
        io_wr     = (state == ST_SEL);
        mem_wr    = (state == ST_WR0) || (state == ST_WR1) || (state == ST_WTAG);
        mem_rd    = (state == ST_RD0) || (state == ST_RD1) || (state == ST_RTAG);
        io_addr   = BANK_PORT;
        mem_addr  = busy ? (WIN_BASE | 16'(offs)) : 16'h0000;
        unique case (state)
            ST_SEL, ST_WTAG, ST_RTAG: exp_byte = bank;
            ST_WR1, ST_RD1:           exp_byte = PAT_ONES;
            default:                  exp_byte = PAT_ZERO;
        endcase
        mem_wdata = (io_wr || mem_wr) ? exp_byte : 8'h00;
    end

    // Completion and compare conditions for the operation in progress.
    always_comb begin
        is_read      = mem_rd;
        mismatch     = is_read && last && (mem_rdata != exp_byte);
        loc_done     = last && ((state == ST_WTAG) || (state == ST_RTAG)) && !mismatch;
        all_done     = loc_done && offs_end && bank_end;
        walk_restart = ((state == ST_IDLE) && start) || (all_done && !pass2);
        walk_step    = loc_done && !(offs_end && bank_end);
    end

    // Sequencer: operation order, pass control and failure capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pass2     <= 1'b0;
            done      <= 1'b0;
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_bank <= '0;
            fail_exp  <= '0;
            fail_obs  <= '0;
        end else begin
            done <= 1'b0;
            if (state == ST_IDLE) begin
                if (start) begin
                    state <= ST_SEL;
                    pass2 <= 1'b0;
                    fail  <= 1'b0;
                end
            end else if (mismatch) begin
                state     <= ST_IDLE;
                done      <= 1'b1;
                fail      <= 1'b1;
                fail_addr <= mem_addr;
                fail_bank <= bank;
                fail_exp  <= exp_byte;
                fail_obs  <= mem_rdata;
            end else if (last) begin
                unique case (state)
                    ST_SEL:  state <= pass2 ? ST_RTAG : ST_WR0;
                    ST_WR0:  state <= ST_RD0;
                    ST_RD0:  state <= ST_WR1;
                    ST_WR1:  state <= ST_RD1;
                    ST_RD1:  state <= ST_WTAG;
                    default: begin
                        if (all_done) begin
                            if (pass2) begin
                                state <= ST_IDLE;
                                done  <= 1'b1;
                            end else begin
                                pass2 <= 1'b1;
                                state <= ST_SEL;
                            end
                        end else if (offs_end) begin
                            state <= ST_SEL;
                        end else begin
                            state <= pass2 ? ST_RTAG : ST_WR0;
                        end
                    end
                endcase
            end
        end
    end

    // R7: done lasts a single cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: the engine is idle whenever done is shown
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R6: failure data holds while idle without a new start
    a_r6_fail_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(fail) && $stable(fail_addr) && $stable(fail_obs)));
    // R3: memory accesses stay inside the window
    a_r3_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> ((mem_addr >> WIN_AW) == (WIN_BASE >> WIN_AW)));
    // R2: bank selects carry a bank number inside the tested range
    a_r2_sel_data: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr |-> (mem_wdata >= 8'(FIRST_BANK) && mem_wdata <= 8'(LAST_BANK)));
    // R1: start while busy never ends the run early
    a_r1_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !last) |=> busy);
    // R9: reset leaves the engine idle with failure cleared
    a_r9_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !fail));

    generate
        if (ACC_CYC > 1) begin : g_hold
            // R8: a read strobe lasts more than one cycle when accesses are slow
            a_r8_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(mem_rd) |=> mem_rd);
        end
    endgenerate
endmodule

// File: tb/ram_march_bist_tb.sv
module ram_march_bist_tb;
    localparam int WA   = 4;
    localparam int ACC  = 2;
    localparam int NLOC = 1 << WA;
    localparam int RUN_CYC = 15 * ACC * (2 + 6 * NLOC);

    // vector: {mode4, fbank4, faddr4, efail4, ebank8, eaddr16, eexp8, eobs8}
    // mode 0 none, 1 bit0 stuck high, 2 bit7 stuck low, 3 bank bit3 ignored
    localparam int NVEC = 5;
    localparam logic [55:0] VEC [NVEC] = '{
        {4'd1, 4'd3,  4'd5,  4'd1, 8'h03, 16'hC005, 8'h00, 8'h01},
        {4'd0, 4'd0,  4'd0,  4'd0, 8'h00, 16'h0000, 8'h00, 8'h00},
        {4'd3, 4'd0,  4'd0,  4'd1, 8'h01, 16'hC000, 8'h01, 8'h09},
        {4'd2, 4'd15, 4'd15, 4'd1, 8'h0F, 16'hC00F, 8'hFF, 8'h7F},
        {4'd1, 4'd1,  4'd0,  4'd1, 8'h01, 16'hC000, 8'h00, 8'h01}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy, done, fail, io_wr, mem_wr, mem_rd;
    logic [15:0] fail_addr, mem_addr;
    logic [7:0] fail_bank, fail_exp, fail_obs, io_addr, mem_wdata, mem_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [7:0] mem [16][NLOC];
    logic [3:0] bank_reg = 4'd0;
    logic [3:0] fmode = 4'd0, fbank = 4'd0, faddr = 4'd0;
    int io_cnt = 0, io_bad = 0, win_bad = 0;
    logic io_prev = 1'b0;

    always #5 clk = ~clk;

    ram_march_bist #(.WIN_AW(WA), .ACC_CYC(ACC)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .fail(fail), .fail_addr(fail_addr), .fail_bank(fail_bank),
        .fail_exp(fail_exp), .fail_obs(fail_obs), .io_wr(io_wr),
        .io_addr(io_addr), .mem_wr(mem_wr), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // memory model with bank latch and injected faults
    logic [3:0] phys;
    logic hit;
    always_comb begin
        phys = (fmode == 4'd3) ? {1'b0, bank_reg[2:0]} : bank_reg;
        hit  = (bank_reg == fbank) && (mem_addr[WA-1:0] == faddr);
        mem_rdata = mem[phys][mem_addr[WA-1:0]];
        if (fmode == 4'd1 && hit) mem_rdata = mem_rdata | 8'h01;
        if (fmode == 4'd2 && hit) mem_rdata = mem_rdata & 8'h7F;
    end

    always @(posedge clk) begin
        if (mem_wr) mem[phys][mem_addr[WA-1:0]] <= mem_wdata;
        if (io_wr && io_addr[7:4] == 4'h7) bank_reg <= mem_wdata[3:0];
    end

    // bus monitors: bank select order and window addresses
    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (io_wr && !io_prev) begin
            if (io_addr != 8'h70 || mem_wdata != 8'((io_cnt % 15) + 1)) io_bad <= io_bad + 1;
            io_cnt <= io_cnt + 1;
        end
        io_prev <= io_wr;
        if ((mem_rd || mem_wr) && mem_addr[15:WA] != (16'hC000 >> WA)) win_bad <= win_bad + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic mem_init();
        for (int b = 0; b < 16; b++)
            for (int a = 0; a < NLOC; a++) mem[b][a] <= 8'hA5;
        @(negedge clk);
    endtask

    // run one test; optional start pulse mid-run; returns busy cycles and done width
    task automatic run(input bit poke, output int bcyc, output int dw);
        bcyc = 0; dw = 0;
        io_cnt = 0; io_bad = 0; win_bad = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            if (busy) bcyc++;
            if (done) break;
            start = (poke && i == 100);
            @(negedge clk);
            start = 1'b0;
        end
        while (done) begin
            dw++;
            @(negedge clk);
        end
    endtask

    // watchdog
    initial begin
        wait (cycles > 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("  == %0d vectors applied, %0d miscompares ==", checks, errors);
        $finish;
    end

    initial begin
        int bc, dw, bad;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset idle", {busy, done, fail, io_wr, mem_wr, mem_rd}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            fmode = VEC[v][55:52]; fbank = VEC[v][51:48]; faddr = VEC[v][47:44];
            mem_init();
            run(1'b0, bc, dw);
            check("R7 done width", dw, 1);
            check("R6 fail flag", fail, VEC[v][40]);
            if (VEC[v][40]) begin
                check("R6 fail_addr", fail_addr, VEC[v][31:16]);
                check("R6 fail_bank", fail_bank, VEC[v][39:32]);
                check("R6 fail_exp", fail_exp, VEC[v][15:8]);
                check("R5 fail_obs", fail_obs, VEC[v][7:0]);
                repeat (8) @(negedge clk);
                check("R6 hold", {fail, fail_addr}, {1'b1, VEC[v][31:16]});
            end else begin
                check("R8 run length", bc, RUN_CYC);
                check("R2 select count", io_cnt, 30);
                check("R2 select order", io_bad, 0);
                check("R3 window", win_bad, 0);
                bad = 0;
                for (int b = 0; b < 16; b++)
                    for (int a = 0; a < NLOC; a++)
                        if (mem[b][a] != ((b == 0) ? 8'hA5 : 8'(b))) bad++;
                check("R4 tags", bad, 0);
            end
        end

        // R1: start while busy has no effect
        fmode = 4'd0;
        mem_init();
        run(1'b1, bc, dw);
        check("R1 start ignored length", bc, RUN_CYC);
        check("R1 start ignored clean", fail, 0);

        // R9: reset mid-run
        fmode = 4'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (50) @(negedge clk);
        check("R1 busy mid-run", busy, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset mid-run", {busy, done, fail, io_wr, mem_wr, mem_rd}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        mem_init();
        run(1'b0, bc, dw);
        check("R9 run after reset", {fail, 31'(bc)}, {1'b0, 31'(RUN_CYC)});

        $display("  == %0d vectors applied, %0d miscompares ==", checks, errors);
        $finish;
    end
endmodule